// File: doc/BRIEF.md
# Streaming Block Programmer for Flash

This controller sits on the host side of a flash device. It programs one erase block in the device's bulk streaming mode. A single `start` pulse latches a base address and a word count. The controller then writes the two-word entry command to the block. It waits a fixed settling time, reads status and checks for setup faults, and then moves data words from a valid/ready source into the block one after another. After every data write it polls the device's per-word busy flag. When the count is used up it leaves the mode by writing one dummy word just past the end of the block. It waits for the device-ready flag and judges the full error status once for the whole block.

The device side is a plain request/acknowledge bus. `bus_req` is held high with a stable address, write flag and write data until `bus_ack` pulses. For a read, `bus_rdata` carries the status byte in the acknowledge cycle. The result is given as a one-cycle `done`, a `pass` flag, a two-bit error code and the last status byte read.

Status byte fields used: bit 7 = device ready, bits 4, 3 and 1 = error flags (mask 0x1A), bit 0 = word-stream busy. Error codes: 0 = none, 1 = setup fault, 2 = poll timeout, 3 = program fault.

Top module: `flash_stream_prog`

## Requirements
- R1: After reset, `busy`, `done`, `bus_req` and `src_ready` are all 0.
- R2: On `start` in idle, the first two bus writes go to the block base (`base_addr` with its low BLK_W bits cleared), carrying 0x30 and then 0xD0.
- R3: No status read is requested until SETUP_DLY cycles have passed after the 0xD0 write is acknowledged.
- R4: If a status read before streaming has any of bits 4, 3 or 1 set, the operation ends with error code 1 and `pass`=0, no data word is accepted or written, and `final_status` holds that byte.
- R5: The first data write comes only after a status read with bit 0 = 0.
- R6: Word k (k from 0) taken from the source is written to block base + k. After each data write, no further write is issued until a status read has returned bit 0 = 0.
- R7: After the last word, exactly one write goes to the first address past the block (block base + 2^BLK_W, wrapping). The controller then polls until status bit 7 = 1.
- R8: On the final read with bit 7 = 1, `final_status` takes that byte. The error code is 3 with `pass`=0 when any of bits 4, 3 or 1 is set, and 0 with `pass`=1 otherwise.
- R9: If a poll state waits POLL_TMO cycles without its exit condition, the operation ends with error code 2 and `pass`=0, and `final_status` holds the last byte read.
- R10: `done` lasts one cycle per operation. A `start` while `busy` is ignored.
- R11: A word count of 0 skips streaming: after a clean setup read the next write is the exit write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin an operation (taken in idle only) |
| base_addr | input | ADDR_W | Any address inside the target block |
| word_cnt | input | BLK_W+1 | Number of words to stream (clamped to 2^BLK_W) |
| src_valid | input | 1 | Source word available |
| src_data | input | DATA_W | Source word |
| src_ready | output | 1 | Controller takes the source word this cycle |
| bus_req | output | 1 | Device access requested, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = status read |
| bus_addr | output | ADDR_W | Device address |
| bus_wdata | output | DATA_W | Device write data |
| bus_ack | input | 1 | Access completed (one-cycle pulse) |
| bus_rdata | input | 8 | Status byte, valid with `bus_ack` on reads |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Last operation succeeded |
| err_code | output | 2 | Last operation's result code |
| final_status | output | 8 | Last status byte read |

## Verification
The assertions assume the device answers with `bus_ack` only while `bus_req` is high. They also assume it never acknowledges in two cycles in a row, so every held request can be checked for a stable address and data until it is answered. The bench's device model follows this: it acknowledges with random delay, only on a pending request, and always drops the acknowledge for a cycle afterwards. The model also keeps track of whether a data write was issued without a clearing status read in between. It is set up per operation to inject busy polls, setup faults, program faults or a stuck busy bit.

// File: rtl/flash_stream_pkg.sv
package flash_stream_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CMD_SETUP,
    ST_CMD_CONFIRM,
    ST_WAIT_SETUP,
    ST_SETUP_POLL,
    ST_SRC_WAIT,
    ST_WORD_WR,
    ST_WORD_POLL,
    ST_LEAVE_WR,
    ST_LEAVE_POLL,
    ST_FINISH
  } fsp_state_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_SETUP   = 2'd1,
    ERR_TIMEOUT = 2'd2,
    ERR_PROGRAM = 2'd3
  } fsp_err_e;

  localparam logic [7:0] SR_ERR_MASK   = 8'h1A;
  localparam int         SR_READY_BIT  = 7;
  localparam int         SR_STREAM_BIT = 0;
  localparam logic [7:0] CMD_ENTER     = 8'h30;
  localparam logic [7:0] CMD_CONFIRM   = 8'hD0;

endpackage

// File: rtl/fsp_wait_timer.sv
module fsp_wait_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // saturating count, restarted on every state change
  assign cnt_en = clr || (cnt_q != {CNT_W{1'b1}});

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/fsp_addr_unit.sv
module fsp_addr_unit #(
  parameter int ADDR_W = 16,
  parameter int BLK_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [BLK_W:0]    cnt_i,
  input  logic              step,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [ADDR_W-1:0] word_addr,
  output logic [ADDR_W-1:0] exit_addr,
  output logic              all_sent
);

  localparam int HI_W = ADDR_W - BLK_W;
  localparam logic [BLK_W:0] BLK_WORDS = (BLK_W+1)'(1) << BLK_W;

  logic [HI_W-1:0] blk_q;
  logic [BLK_W:0]  off_q, off_d;
  logic [BLK_W:0]  total_q, total_d;
  logic            off_en;

  always_comb begin
    total_d = (cnt_i > BLK_WORDS) ? BLK_WORDS : cnt_i;
    off_en  = load || step;
    off_d   = load ? '0 : off_q + (BLK_W+1)'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q   <= '0;
      total_q <= '0;
    end else if (load) begin
      blk_q   <= base_i[ADDR_W-1:BLK_W];
      total_q <= total_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_q <= '0;
    else if (off_en) off_q <= off_d;
  end

  assign cmd_addr  = {blk_q, {BLK_W{1'b0}}};
  assign word_addr = {blk_q, off_q[BLK_W-1:0]};
  assign exit_addr = {blk_q + HI_W'(1), {BLK_W{1'b0}}};
  assign all_sent  = (off_q == total_q);

endmodule

// File: rtl/fsp_status_decode.sv
module fsp_status_decode
  import flash_stream_pkg::*;
(
  input  logic [7:0] status,
  output logic       err_hit,
  output logic       stream_idle,
  output logic       dev_ready
);

  assign err_hit     = |(status & SR_ERR_MASK);
  assign stream_idle = ~status[SR_STREAM_BIT];
  assign dev_ready   = status[SR_READY_BIT];

endmodule

// File: rtl/flash_stream_prog.sv
module flash_stream_prog
  import flash_stream_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int BLK_W     = 8,
  parameter int SETUP_DLY = 32,
  parameter int POLL_TMO  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [BLK_W:0]    word_cnt,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [7:0]        bus_rdata,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [1:0]        err_code,
  output logic [7:0]        final_status
);

  localparam int TMR_MAX = (SETUP_DLY > POLL_TMO) ? SETUP_DLY : POLL_TMO;
  localparam int TMR_W   = $clog2(TMR_MAX + 1) + 1;
  localparam logic [TMR_W-1:0] DLY_LAST = TMR_W'(SETUP_DLY - 1);
  localparam logic [TMR_W-1:0] TMO_LAST = TMR_W'(POLL_TMO - 1);

  fsp_state_e        state_q, state_d;
  fsp_err_e          err_q, err_d;
  logic              pass_q, pass_d;
  logic [7:0]        stat_q, stat_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              res_en, data_en;

  logic              au_load, au_step, au_all_sent;
  logic [ADDR_W-1:0] au_cmd_addr, au_word_addr, au_exit_addr;
  logic              tmr_clr;
  logic [TMR_W-1:0]  tmr_cnt;
  logic              sr_err, sr_idle, sr_ready;
  logic              poll_expired;

  fsp_addr_unit #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) addr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (au_load),
    .base_i    (base_addr),
    .cnt_i     (word_cnt),
    .step      (au_step),
    .cmd_addr  (au_cmd_addr),
    .word_addr (au_word_addr),
    .exit_addr (au_exit_addr),
    .all_sent  (au_all_sent)
  );

  fsp_wait_timer #(.CNT_W(TMR_W)) tmr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .cnt_o (tmr_cnt)
  );

  fsp_status_decode sdec_i (
    .status      (bus_rdata),
    .err_hit     (sr_err),
    .stream_idle (sr_idle),
    .dev_ready   (sr_ready)
  );

  assign poll_expired = (tmr_cnt >= TMO_LAST);

  always_comb begin
    state_d   = state_q;
    err_d     = err_q;
    pass_d    = pass_q;
    stat_d    = stat_q;
    data_d    = data_q;
    au_load   = 1'b0;
    au_step   = 1'b0;
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = au_cmd_addr;
    bus_wdata = '0;
    src_ready = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          au_load = 1'b1;
          state_d = ST_CMD_SETUP;
        end
      end
      ST_CMD_SETUP: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_wdata = DATA_W'(CMD_ENTER);
        if (bus_ack) state_d = ST_CMD_CONFIRM;
      end
      ST_CMD_CONFIRM: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_wdata = DATA_W'(CMD_CONFIRM);
        if (bus_ack) state_d = ST_WAIT_SETUP;
      end
      ST_WAIT_SETUP: begin
        if (tmr_cnt >= DLY_LAST) state_d = ST_SETUP_POLL;
      end
      ST_SETUP_POLL: begin
        bus_req = 1'b1;
        if (bus_ack) begin
          stat_d = bus_rdata;
          if (sr_err) begin
            err_d   = ERR_SETUP;
            pass_d  = 1'b0;
            state_d = ST_FINISH;
          end else if (sr_idle) begin
            state_d = au_all_sent ? ST_LEAVE_WR : ST_SRC_WAIT;
          end
        end else if (poll_expired) begin
          err_d   = ERR_TIMEOUT;
          pass_d  = 1'b0;
          state_d = ST_FINISH;
        end
      end
      ST_SRC_WAIT: begin
        src_ready = 1'b1;
        if (src_valid) begin
          data_d  = src_data;
          state_d = ST_WORD_WR;
        end
      end
      ST_WORD_WR: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = au_word_addr;
        bus_wdata = data_q;
        if (bus_ack) begin
          au_step = 1'b1;
          state_d = ST_WORD_POLL;
        end
      end
      ST_WORD_POLL: begin
        bus_req = 1'b1;
        if (bus_ack) begin
          stat_d = bus_rdata;
          if (sr_idle) state_d = au_all_sent ? ST_LEAVE_WR : ST_SRC_WAIT;
        end else if (poll_expired) begin
          err_d   = ERR_TIMEOUT;
          pass_d  = 1'b0;
          state_d = ST_FINISH;
        end
      end
      ST_LEAVE_WR: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = au_exit_addr;
        bus_wdata = {DATA_W{1'b1}};
        if (bus_ack) state_d = ST_LEAVE_POLL;
      end
      ST_LEAVE_POLL: begin
        bus_req = 1'b1;
        if (bus_ack) begin
          stat_d = bus_rdata;
          if (sr_ready) begin
            err_d   = sr_err ? ERR_PROGRAM : ERR_NONE;
            pass_d  = ~sr_err;
            state_d = ST_FINISH;
          end
        end else if (poll_expired) begin
          err_d   = ERR_TIMEOUT;
          pass_d  = 1'b0;
          state_d = ST_FINISH;
        end
      end
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign tmr_clr = (state_d != state_q);
  assign res_en  = (state_q != ST_IDLE);
  assign data_en = (state_q == ST_SRC_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= ERR_NONE;
      pass_q <= 1'b0;
      stat_q <= '0;
    end else if (res_en) begin
      err_q  <= err_d;
      pass_q <= pass_d;
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign busy         = (state_q != ST_IDLE);
  assign done         = (state_q == ST_FINISH);
  assign pass         = pass_q;
  assign err_code     = err_q;
  assign final_status = stat_q;

endmodule

// File: rtl/fsp_checker.sv
module fsp_checker
  import flash_stream_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ack,
  input logic              src_ready,
  input logic              busy,
  input logic              done,
  input logic [1:0]        err_code,
  input logic [7:0]        final_status
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_req && !src_ready && !done));

  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=>
      (done || (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata))));

  assert_take_not_during_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> !bus_req);

  assert_setup_fault_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == ERR_SETUP) |-> ((final_status & SR_ERR_MASK) != 8'h00));

  assert_prog_fault_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == ERR_PROGRAM) |-> (final_status[SR_READY_BIT] && ((final_status & SR_ERR_MASK) != 8'h00)));

  assert_clean_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == ERR_NONE) |-> (final_status[SR_READY_BIT] && ((final_status & SR_ERR_MASK) == 8'h00)));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind flash_stream_prog fsp_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_req      (bus_req),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_ack      (bus_ack),
  .src_ready    (src_ready),
  .busy         (busy),
  .done         (done),
  .err_code     (err_code),
  .final_status (final_status)
);

// File: tb/flash_stream_prog_tb.sv
module flash_stream_prog_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;
  localparam int DATA_W     = 16;
  localparam int BLK_W      = 5;
  localparam int SETUP_DLY  = 10;
  localparam int POLL_TMO   = 40;
  localparam int HI_W       = ADDR_W - BLK_W;
  localparam int BLK_WORDS  = 1 << BLK_W;

  logic              clk, rst_n, start;
  logic [ADDR_W-1:0] base_addr;
  logic [BLK_W:0]    word_cnt;
  logic              src_valid, src_ready;
  logic [DATA_W-1:0] src_data;
  logic              bus_req, bus_we, bus_ack;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [7:0]        bus_rdata;
  logic              busy, done, pass;
  logic [1:0]        err_code;
  logic [7:0]        final_status;

  flash_stream_prog #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W),
    .SETUP_DLY(SETUP_DLY), .POLL_TMO(POLL_TMO)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .word_cnt(word_cnt), .src_valid(src_valid), .src_data(src_data),
    .src_ready(src_ready), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .busy(busy), .done(done), .pass(pass),
    .err_code(err_code), .final_status(final_status)
  );

  int n_checks = 0;
  int n_fails  = 0;
  int cyc_all  = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_all <= cyc_all + 1;
    if (cyc_all > 150000) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run hung act=%0d exp<=150000", cyc_all);
      finish_up();
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic              mdl_clr;
  logic [HI_W-1:0]   cur_blk;
  logic [7:0]        cfg_setup_err, cfg_final;
  int                cfg_setup_busy, cfg_busy_polls, cfg_exit_polls;
  bit                cfg_hang;
  logic [ADDR_W-1:0] wr_addr [0:79];
  logic [DATA_W-1:0] wr_data [0:79];
  int                wr_n, rd_n, busy_left, exit_left, d0_cyc, first_rd, mcyc, taken;
  bit                exit_mode, need_rd, viol;
  logic [DATA_W-1:0] src_mem [0:63];

  always @(posedge clk) begin
    mcyc <= mcyc + 1;
    if (mdl_clr) begin
      wr_n <= 0; rd_n <= 0; viol <= 0; exit_mode <= 0; exit_left <= 0;
      busy_left <= cfg_setup_busy; need_rd <= 0; d0_cyc <= 0; first_rd <= 0;
      bus_ack <= 1'b0; taken <= 0;
    end else begin
      if (src_valid && src_ready) taken <= taken + 1;
      if (bus_ack) bus_ack <= 1'b0;
      else if (bus_req && ($urandom % 3 != 0)) begin
        bus_ack <= 1'b1;
        if (bus_we) begin
          if (wr_n < 80) begin
            wr_addr[wr_n] <= bus_addr;
            wr_data[wr_n] <= bus_wdata;
          end
          wr_n <= wr_n + 1;
          if (wr_n == 1) begin d0_cyc <= mcyc; need_rd <= 1; end
          if (wr_n >= 2) begin
            if (bus_addr[ADDR_W-1:BLK_W] != cur_blk) begin
              exit_mode <= 1; exit_left <= cfg_exit_polls;
            end else begin
              if (need_rd || exit_mode) viol <= 1;
              need_rd <= 1; busy_left <= cfg_busy_polls;
            end
          end
        end else begin
          rd_n <= rd_n + 1;
          if (rd_n == 0) first_rd <= mcyc;
          if (exit_mode) begin
            if (exit_left != 0) begin bus_rdata <= 8'h00; exit_left <= exit_left - 1; end
            else bus_rdata <= 8'h80 | cfg_final;
          end else if (cfg_setup_err != 0) bus_rdata <= cfg_setup_err;
          else if (cfg_hang && wr_n > 2) bus_rdata <= 8'h01;
          else if (busy_left != 0) begin bus_rdata <= 8'h01; busy_left <= busy_left - 1; end
          else begin bus_rdata <= 8'h00; need_rd <= 0; end
        end
      end
    end
  end

  always @(negedge clk) begin
    src_valid = (taken < int'(word_cnt)) && (taken < 64) && ($urandom % 4 != 0);
    src_data  = src_mem[taken % 64];
  end

  // ---------------- expected-value functions ----------------
  function automatic logic [ADDR_W-1:0] exp_word_addr(input logic [ADDR_W-1:0] b, input int k);
    return {b[ADDR_W-1:BLK_W], {BLK_W{1'b0}}} + ADDR_W'(k);
  endfunction

  function automatic logic [ADDR_W-1:0] exp_exit_addr(input logic [ADDR_W-1:0] b);
    return {b[ADDR_W-1:BLK_W] + HI_W'(1), {BLK_W{1'b0}}};
  endfunction

  function automatic int exp_code(input logic [7:0] s_err, input bit hang, input logic [7:0] fin);
    if ((s_err & 8'h1A) != 0) return 1;
    if (hang) return 2;
    if ((fin & 8'h1A) != 0) return 3;
    return 0;
  endfunction

  // ---------------- one operation ----------------
  task automatic run_op(input logic [ADDR_W-1:0] b, input int cnt, input logic [7:0] s_err,
                        input int s_busy, input int w_busy, input int x_polls,
                        input logic [7:0] fin, input bit hang, input bit poke);
    int code, eff, lim, n30;
    bit ok;
    eff = (cnt > BLK_WORDS) ? BLK_WORDS : cnt;
    for (int i = 0; i < 64; i++) src_mem[i] = DATA_W'($urandom);
    cur_blk = b[ADDR_W-1:BLK_W];
    cfg_setup_err = s_err; cfg_setup_busy = s_busy; cfg_busy_polls = w_busy;
    cfg_exit_polls = x_polls; cfg_final = fin; cfg_hang = hang;
    @(negedge clk); mdl_clr = 1'b1; word_cnt = '0;
    @(negedge clk); mdl_clr = 1'b0;
    start = 1'b1; base_addr = b; word_cnt = (BLK_W+1)'(cnt);
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (30) @(negedge clk);
      start = 1'b1; base_addr = b ^ {1'b1, {(ADDR_W-1){1'b0}}};
      @(negedge clk); start = 1'b0;
    end
    lim = 0;
    while (!done && lim < 20000) begin @(negedge clk); lim++; end
    chk(done, "R10 done seen", int'(done), 1);
    code = exp_code(s_err, hang, fin);
    chk(wr_n >= 2 && wr_addr[0] == exp_word_addr(b, 0) && wr_data[0] == 16'h0030,
        "R2 enter command", int'(wr_data[0]), 16'h0030);
    chk(wr_addr[1] == exp_word_addr(b, 0) && wr_data[1] == 16'h00D0,
        "R2 confirm command", int'(wr_data[1]), 16'h00D0);
    chk(first_rd - d0_cyc >= SETUP_DLY + 2, "R3 setup delay", first_rd - d0_cyc, SETUP_DLY + 2);
    chk(int'(err_code) == code, "R4/R8/R9 error code", int'(err_code), code);
    chk(pass == (code == 0), "R8 pass flag", int'(pass), int'(code == 0));
    if (code == 1) begin
      chk(wr_n == 2 && taken == 0, "R4 no streaming after setup fault", wr_n, 2);
      chk(final_status == s_err, "R4 status", final_status, s_err);
    end else if (code == 2) begin
      chk(final_status == 8'h01, "R9 status on timeout", final_status, 8'h01);
    end else begin
      chk(!viol, "R5/R6 write before clearing read", int'(viol), 0);
      chk(wr_n == eff + 3, "R7 write count", wr_n, eff + 3);
      ok = 1;
      for (int k = 0; k < eff; k++)
        if (wr_addr[2+k] != exp_word_addr(b, k) || wr_data[2+k] != src_mem[k]) ok = 0;
      chk(ok, "R6 data addresses and words", int'(ok), 1);
      chk(wr_addr[2+eff] == exp_exit_addr(b), "R7 exit address",
          int'(wr_addr[2+eff]), int'(exp_exit_addr(b)));
      chk(final_status == (8'h80 | fin), "R8 final status", final_status, 8'h80 | fin);
      if (eff == 0) chk(taken == 0, "R11 no source words", taken, 0);
    end
    n30 = 0;
    for (int k = 0; k < wr_n && k < 80; k++) if (wr_data[k] == 16'h0030 && k != 2) n30 += (k < 2) ? 1 : 0;
    if (poke) chk(n30 == 1 && busy, "R10 start ignored while busy", n30, 1);
    @(negedge clk);
    chk(!done, "R10 done one cycle", int'(done), 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; start = 1'b0; mdl_clr = 1'b1; base_addr = '0; word_cnt = '0;
    cfg_setup_err = 0; cfg_final = 0; cfg_setup_busy = 0; cfg_busy_polls = 0;
    cfg_exit_polls = 0; cfg_hang = 0; cur_blk = '0; mcyc = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !bus_req && !src_ready, "R1 reset state", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !bus_req && !src_ready, "R1 idle after reset", int'(bus_req), 0);
    // directed cases
    run_op(12'h0A0, 4, 8'h00, 1, 1, 1, 8'h00, 0, 0);
    run_op(12'h3C7, 0, 8'h00, 0, 0, 2, 8'h00, 0, 0);   // R11, low base bits set (R2)
    run_op(12'h040, 32, 8'h00, 0, 2, 0, 8'h00, 0, 0);  // full block
    run_op(12'hFE0, 3, 8'h00, 0, 0, 0, 8'h00, 0, 0);   // exit address wraps (R7)
    run_op(12'h100, 5, 8'h10, 0, 0, 0, 8'h00, 0, 0);   // R4
    run_op(12'h100, 5, 8'h08, 0, 0, 0, 8'h00, 0, 0);
    run_op(12'h100, 5, 8'h02, 2, 0, 0, 8'h00, 0, 0);
    run_op(12'h200, 6, 8'h00, 2, 1, 3, 8'h10, 0, 0);   // R8 program fault
    run_op(12'h220, 6, 8'h00, 0, 1, 0, 8'h02, 0, 0);
    run_op(12'h300, 4, 8'h00, 0, 0, 0, 8'h00, 1, 0);   // R9 timeout
    run_op(12'h460, 20, 8'h00, 0, 3, 1, 8'h00, 0, 1);  // R10 start while busy
    // constrained random
    for (int r = 0; r < 12; r++) begin
      logic [7:0] f;
      case ($urandom % 5)
        0: f = 8'h10; 1: f = 8'h08; default: f = 8'h00;
      endcase
      run_op(ADDR_W'($urandom), int'($urandom % 34), 8'h00, int'($urandom % 3),
             int'($urandom % 3), int'($urandom % 3), f, 0, 0);
    end
    finish_up();
  end

endmodule